// File: doc/BRIEF.md
# Vectored Interrupt Controller for an 8-bit Core

This block arbitrates four interrupt sources for a small 8-bit microcontroller core: an external pin, two timer/event counters and a serial receiver/transmitter. The core reads and writes two byte-wide control registers through a simple register port. Each register holds per-source enable bits and request flags. The primary register also holds the master enable. The external source latches a request on a falling edge of its pin. The other three sources latch a request on a one-cycle event pulse.

Requests are sampled only on an instruction-cycle strobe from the core. On such a strobe the controller takes the request if the master enable is set, at least one source is both flagged and enabled, and the core reports that its return stack has room. Taking a request does three things:
- it pulses a call request carrying a fixed vector address;
- it clears the serviced flag;
- it clears the master enable, which blocks nesting.

A return strobe tells the controller which kind of return the core executed. Only the interrupt-return kind sets the master enable again. A wake output tells a sleeping core that some enabled request is waiting.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, both registers read 0x00, call_req is 0 and wake is 0.
- R2: With reg_sel=0 the register reads as follows:
  - bit0 is the master enable;
  - bits 1, 2 and 3 are the enables for external, timer0 and timer1;
  - bits 4, 5 and 6 are the request flags for external, timer0 and timer1;
  - bit7 reads 0.
  A write with reg_sel=0 loads bits 0 to 6.
- R3: With reg_sel=1, bit0 is the UART enable and bit4 is the UART request flag. All other bits read 0. A write with reg_sel=1 loads bits 0 and 4.
- R4: A high-to-low transition of ext_pin, seen between two consecutive clock edges, sets the external flag on the next edge. A rising edge or a steady level sets nothing.
- R5: A request is taken only on a clock edge where all of the following hold: cyc_tick=1, master enable=1, stack_full=0, and some source has both its flag and its enable at 1. Otherwise the request stays pending and is taken at a later qualifying tick.
- R6: call_vec gives the vector of the source taken: 0x04 for external, 0x08 for timer0, 0x0C for timer1, 0x10 for UART. When several sources are eligible, priority is external, then timer0, then timer1, then UART.
- R7: On the edge that takes a request, the master enable and the taken flag clear. call_req is 1 for exactly the following cycle.
- R8: Flags keep latching while the master enable is 0. Those requests are taken once software sets the master enable.
- R9: A strobe on ret_stb with ret_reti=1 sets the master enable. With ret_reti=0 the master enable is unchanged.
- R10: wake is 1 whenever any source has both its flag and its enable set, regardless of the master enable.
- R11: If a source event arrives in the same cycle as a register write or a take that clears that source's flag, the flag is set after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_tick | input | 1 | Instruction-cycle sampling strobe |
| ext_pin | input | 1 | External interrupt pin, idle high |
| tmr0_evt | input | 1 | Timer0 overflow pulse |
| tmr1_evt | input | 1 | Timer1 overflow pulse |
| uart_evt | input | 1 | UART event pulse |
| stack_full | input | 1 | Core return stack has no room |
| ret_stb | input | 1 | Core executed a return |
| ret_reti | input | 1 | With ret_stb: 1 means interrupt-return |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the primary register, 1 the UART register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| call_req | output | 1 | One-cycle call request to the core |
| call_vec | output | VW | Vector address of the call |
| wake | output | 1 | An enabled request is pending |

## Verification
The hardest situation to reach from the ports is a clash inside a single cycle, where a source event coincides with a register write, or with the take, that would clear the same flag. A second hard case is a take that is held off by stack_full or by the tick timing and then released. Directed sequences build both situations on purpose. The first loads all four flags with the master enable off, walks them out in priority order, and lands an event on the same edge as the clearing write. A long random phase then mixes sparse ticks, stack-full phases, both return kinds and pin toggles. In that phase every cycle is compared against a bench model.

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_tick,
  input  logic          ext_pin,
  input  logic          tmr0_evt,
  input  logic          tmr1_evt,
  input  logic          uart_evt,
  input  logic          stack_full,
  input  logic          ret_stb,
  input  logic          ret_reti,
  input  logic          reg_wr,
  input  logic          reg_sel,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          call_req,
  output logic [VW-1:0] call_vec,
  output logic          wake
);
  localparam logic [VW-1:0] V_EXT  = VW'(4);
  localparam logic [VW-1:0] V_TMR0 = VW'(8);
  localparam logic [VW-1:0] V_TMR1 = VW'(12);
  localparam logic [VW-1:0] V_UART = VW'(16);

  // source order: 0 ext, 1 tmr0, 2 tmr1, 3 uart (also priority order)
  logic       emi, ext_q;
  logic [3:0] en, flg;
  logic       emi_n;
  logic [3:0] en_n, flg_n;

  wire       fall   = ext_q & ~ext_pin;
  wire [3:0] evt    = {uart_evt, tmr1_evt, tmr0_evt, fall};
  wire [3:0] elig   = en & flg;
  wire [3:0] pick   = elig & (~elig + 4'd1);
  wire       take   = cyc_tick & emi & ~stack_full & (|elig);
  wire       wr_pri = reg_wr & ~reg_sel;
  wire       wr_sec = reg_wr & reg_sel;

  always_comb begin
    en_n  = en;
    flg_n = flg;
    if (wr_pri) begin
      en_n[2:0]  = reg_wdata[3:1];
      flg_n[2:0] = reg_wdata[6:4];
    end
    if (wr_sec) begin
      en_n[3]  = reg_wdata[0];
      flg_n[3] = reg_wdata[4];
    end
    if (take) flg_n = flg_n & ~pick;
    flg_n = flg_n | evt;

    if (take)                    emi_n = 1'b0;
    else if (ret_stb & ret_reti) emi_n = 1'b1;
    else if (wr_pri)             emi_n = reg_wdata[0];
    else                         emi_n = emi;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      emi      <= 1'b0;
      en       <= '0;
      flg      <= '0;
      ext_q    <= 1'b1;
      call_req <= 1'b0;
      call_vec <= '0;
    end else begin
      emi      <= emi_n;
      en       <= en_n;
      flg      <= flg_n;
      ext_q    <= ext_pin;
      call_req <= take;
      if (take) begin
        unique case (1'b1)
          pick[0]: call_vec <= V_EXT;
          pick[1]: call_vec <= V_TMR0;
          pick[2]: call_vec <= V_TMR1;
          default: call_vec <= V_UART;
        endcase
      end
    end
  end

  assign reg_rdata = reg_sel ? {3'b000, flg[3], 3'b000, en[3]}
                             : {1'b0, flg[2:0], en[2:0], emi};
  assign wake = |elig;
endmodule

module vec_irq_ctrl_chk #(
  parameter int VW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cyc_tick,
  input logic          stack_full,
  input logic          ext_pin,
  input logic          ret_stb,
  input logic          ret_reti,
  input logic          call_req,
  input logic [VW-1:0] call_vec,
  input logic          emi,
  input logic [3:0]    flg,
  input logic          wake
);
  // R5
  take_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> $past(cyc_tick && !stack_full));
  // R6
  vector_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> (call_vec == VW'(4) || call_vec == VW'(8) ||
                  call_vec == VW'(12) || call_vec == VW'(16)));
  // R7
  master_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> !emi);
  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |=> !call_req);
  // R4
  ext_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_pin) |=> flg[0]);
  // R9
  reti_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_stb && ret_reti) |=> (emi || call_req));
  // R10
  wake_before_call_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> $past(wake));
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(.VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .stack_full(stack_full),
  .ext_pin(ext_pin), .ret_stb(ret_stb), .ret_reti(ret_reti),
  .call_req(call_req), .call_vec(call_vec), .emi(emi), .flg(flg), .wake(wake)
);

// File: tb/vec_irq_ctrl_bench.sv
module vec_irq_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_tick = 0, ext_pin = 1, tmr0_evt = 0, tmr1_evt = 0, uart_evt = 0;
  logic stack_full = 0, ret_stb = 0, ret_reti = 0, reg_wr = 0, reg_sel = 0;
  logic [7:0] reg_wdata = 0, reg_rdata, call_vec;
  logic call_req, wake;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  vec_irq_ctrl u_vec_irq_ctrl (.*);

  // bench model, from the requirements
  logic       m_emi = 0, m_extq = 1, m_creq = 0;
  logic [3:0] m_en = 0, m_flg = 0;
  logic [7:0] m_cvec = 0;
  logic       n_emi, n_extq, n_creq;
  logic [3:0] n_en, n_flg;
  logic [7:0] n_cvec;

  function automatic logic [7:0] vec_of(input int src);
    return 8'(4 + 4 * src);
  endfunction

  function automatic logic [7:0] rd_of(input logic sel);
    return sel ? {3'b000, m_flg[3], 3'b000, m_en[3]}
               : {1'b0, m_flg[2:0], m_en[2:0], m_emi};
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_next();
    logic [3:0] el;
    logic tk;
    int src;
    el = m_en & m_flg;
    tk = cyc_tick && m_emi && !stack_full && (el != 0);
    src = 3;
    for (int i = 3; i >= 0; i--) if (el[i]) src = i;
    n_en = m_en;
    n_flg = m_flg;
    if (reg_wr && !reg_sel) begin n_en[2:0] = reg_wdata[3:1]; n_flg[2:0] = reg_wdata[6:4]; end
    if (reg_wr && reg_sel)  begin n_en[3] = reg_wdata[0];    n_flg[3] = reg_wdata[4];    end
    if (tk) n_flg[src] = 1'b0;
    n_flg = n_flg | {uart_evt, tmr1_evt, tmr0_evt, m_extq & ~ext_pin};
    n_emi = tk ? 1'b0 : (ret_stb && ret_reti) ? 1'b1 : (reg_wr && !reg_sel) ? reg_wdata[0] : m_emi;
    n_extq = ext_pin;
    n_creq = tk;
    n_cvec = tk ? vec_of(src) : m_cvec;
  endtask

  task automatic cycle();
    model_next();
    @(negedge clk);
    m_emi = n_emi; m_en = n_en; m_flg = n_flg; m_extq = n_extq;
    m_creq = n_creq; m_cvec = n_cvec;
    chk(reg_sel ? "R3 read" : "R2 read", reg_rdata, rd_of(reg_sel));
    chk("R7 call_req", {7'd0, call_req}, {7'd0, m_creq});
    if (m_creq) chk("R6 call_vec", call_vec, m_cvec);
    chk("R10 wake", {7'd0, wake}, {7'd0, |(m_en & m_flg)});
    cyc_tick = 0; tmr0_evt = 0; tmr1_evt = 0; uart_evt = 0;
    ret_stb = 0; ret_reti = 0; reg_wr = 0;
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    reg_wr = 1; reg_sel = sel; reg_wdata = d;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 main", reg_rdata, 8'h00);
    reg_sel = 1; #1;
    chk("R1 uart", reg_rdata, 8'h00);
    chk("R1 call_req", {7'd0, call_req}, 8'h00);
    chk("R1 wake", {7'd0, wake}, 8'h00);
    reg_sel = 0;

    // R8: enables on, master off, all sources fire
    wr(0, 8'h0E); cycle();
    wr(1, 8'hFF); cycle();
    chk("R3 unused bits", reg_rdata, 8'h11);
    reg_sel = 0;
    ext_pin = 0; tmr0_evt = 1; tmr1_evt = 1; uart_evt = 1; cyc_tick = 1; cycle();
    chk("R8 no call while master off", {7'd0, call_req}, 8'h00);
    chk("R8 flags latched", reg_rdata, 8'h7E);
    chk("R10 wake with master off", {7'd0, wake}, 8'h01);
    // R4: rising edge alone does nothing new
    ext_pin = 1; cycle();

    // R5: master on but stack full
    wr(0, 8'h7F); cycle();
    stack_full = 1; cyc_tick = 1; cycle();
    chk("R5 held by stack_full", {7'd0, call_req}, 8'h00);
    stack_full = 0; cycle();
    chk("R5 no take without tick", {7'd0, call_req}, 8'h00);
    cyc_tick = 1; cycle();
    chk("R6 ext first", call_vec, 8'h04);
    chk("R7 master and ext flag cleared", reg_rdata, 8'h6E);
    // R9: plain return leaves master off
    ret_stb = 1; ret_reti = 0; cycle();
    chk("R9 plain return", reg_rdata, 8'h6E);
    ret_stb = 1; ret_reti = 1; cycle();
    chk("R9 interrupt return", reg_rdata, 8'h6F);
    cyc_tick = 1; cycle();
    chk("R6 timer0 next", call_vec, 8'h08);
    ret_stb = 1; ret_reti = 1; cycle();
    cyc_tick = 1; cycle();
    chk("R6 timer1 next", call_vec, 8'h0C);
    ret_stb = 1; ret_reti = 1; cycle();
    cyc_tick = 1; cycle();
    chk("R6 uart last", call_vec, 8'h10);

    // R11: clearing write collides with a timer0 event
    wr(0, 8'h0E); tmr0_evt = 1; cycle();
    chk("R11 event beats write", reg_rdata, 8'h2E);
    // R11: take collides with a new event of the same source
    wr(0, 8'h2F); cycle();
    cyc_tick = 1; tmr0_evt = 1; cycle();
    chk("R11 event beats take", reg_rdata, 8'h2E);
    // R4: falling edge sets the external flag
    ext_pin = 0; cycle();
    chk("R4 falling edge", reg_rdata, 8'h3E);
    ext_pin = 1;

    // random phase, fixed seed
    void'($urandom(32'd1234));
    for (int n = 0; n < 4000; n++) begin
      cyc_tick   = ($urandom % 4) == 0;
      stack_full = ($urandom % 4) == 0;
      tmr0_evt   = ($urandom % 12) == 0;
      tmr1_evt   = ($urandom % 12) == 0;
      uart_evt   = ($urandom % 12) == 0;
      if (($urandom % 6) == 0) ext_pin = ~ext_pin;
      ret_stb    = ($urandom % 10) == 0;
      ret_reti   = $urandom % 2;
      reg_sel    = $urandom % 2;
      if (($urandom % 8) == 0) begin
        reg_wr = 1;
        reg_wdata = 8'($urandom);
      end
      cycle();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule